// File: doc/BRIEF.md
# Condition Register Logic Unit

This block owns a 32-bit condition register split into eight 4-bit fields and carries out the register-side work of integer compares, field-to-field copies, nibble-masked loads from a general register and single-bit boolean operations between condition bits. Each cycle an operation code and its operands arrive. A valid operation changes only the bits it targets, and the register commits the result on the next rising clock edge.

Both bit and field selectors count from the most significant end. Field k covers bits 31-4k down to 28-4k. Bit index n addresses bit 31-n. Writes are merged through a 32-bit write mask, so each operation changes exactly one field, a chosen set of nibbles, or a single bit.

Two outputs are provided. `cr_rd` shows the committed register. `cr_next` shows the value that the current operation will commit at the next edge. The register clears to zero on reset.

Top module: `crlu_top`

## Requirements
- R1: After reset, `cr_rd` reads 0x00000000.
- R2: Operation code 1 performs a signed compare of `opnd_a` against the second operand. Field `fld_dst` receives {lt, gt, eq, so_in}, with lt in the most significant bit of the field. No other field changes.
- R3: Operation code 2 performs the same compare with both operands treated as unsigned.
- R4: When `use_imm` is 1, the second compare operand is `imm16`. It is sign-extended for code 1 and zero-extended for code 2. When `use_imm` is 0, the second operand is `opnd_b`.
- R5: Operation code 4 copies nibble i, which is bits 4i+3 down to 4i, from `opnd_a` for every set bit i of `fxm`. All other nibbles keep their value.
- R6: Operation code 5 combines register bit 31-`bit_a` (x) with bit 31-`bit_b` (y) and writes the result to bit 31-`bit_t`. The function is selected by `xo`: 257 x&y, 449 x|y, 255 ~(x&y), 193 x^y, 33 ~(x|y), 289 ~(x^y), 129 x&~y, 417 x|~y. Only that one bit may change.
- R7: Under operation code 5, an `xo` value outside that set of eight leaves the register unchanged.
- R8: Operation code 3 copies field `fld_src` into field `fld_dst`. All other fields are unchanged.
- R9: When `op_valid` is 0, or when the operation code is 0, 6 or 7, the register holds its value.
- R10: During the cycle an operation is presented, `cr_rd` shows the pre-update value and `cr_next` shows the post-update value. After the next rising edge, `cr_rd` equals that `cr_next`.
- R11: After any compare, exactly one of the lt, gt and eq flags in the written field is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 1 signed cmp, 2 unsigned cmp, 3 field copy, 4 masked load, 5 bit op |
| opnd_a | input | 32 | First compare operand / masked load source |
| opnd_b | input | 32 | Second compare operand |
| imm16 | input | 16 | Immediate compare operand |
| use_imm | input | 1 | Select `imm16` as second compare operand |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index for field copy |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_t | input | 5 | Target bit index |
| xo | input | 10 | Bit operation function code |
| fxm | input | 8 | Nibble select mask for masked load |
| so_in | input | 1 | Summary-overflow bit copied by compares |
| cr_next | output | 32 | Value to be committed at next edge |
| cr_rd | output | 32 | Committed register contents |

## Verification
The assertions assume the inputs are stable and known (no X) while `op_valid` is high. They also assume that reset deassertion reaches the register only through the internal two-stage synchronizer, so the checker uses the synchronized reset. The bench changes every input only at the falling clock edge and draws operation codes, selectors and function codes from their full legal ranges, with occasional undefined codes. This keeps every presented value known and settled before the rising edge that commits it.

// File: rtl/crlu_pkg.sv
package crlu_pkg;
  localparam int CR_W  = 32;
  localparam int FLD_W = 4;
  localparam int N_FLD = CR_W / FLD_W;
  localparam int FI_W  = $clog2(N_FLD);
  localparam int BI_W  = $clog2(CR_W);
  localparam int XO_W  = 10;
  localparam int IMM_W = 16;

  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_CMPS  = 3'd1;
  localparam logic [2:0] OP_CMPU  = 3'd2;
  localparam logic [2:0] OP_FMOVE = 3'd3;
  localparam logic [2:0] OP_MASK  = 3'd4;
  localparam logic [2:0] OP_BIT   = 3'd5;

  localparam logic [XO_W-1:0] XO_AND  = 10'd257;
  localparam logic [XO_W-1:0] XO_OR   = 10'd449;
  localparam logic [XO_W-1:0] XO_NAND = 10'd255;
  localparam logic [XO_W-1:0] XO_XOR  = 10'd193;
  localparam logic [XO_W-1:0] XO_NOR  = 10'd33;
  localparam logic [XO_W-1:0] XO_EQV  = 10'd289;
  localparam logic [XO_W-1:0] XO_ANDC = 10'd129;
  localparam logic [XO_W-1:0] XO_ORC  = 10'd417;

  function automatic logic xo_known(input logic [XO_W-1:0] x);
    return (x == XO_AND) || (x == XO_OR) || (x == XO_NAND) || (x == XO_XOR) ||
           (x == XO_NOR) || (x == XO_EQV) || (x == XO_ANDC) || (x == XO_ORC);
  endfunction

  // Mask covering field k, field 0 at the most significant end
  function automatic logic [CR_W-1:0] fld_mask(input logic [FI_W-1:0] k);
    logic [CR_W-1:0] base;
    base = {{(CR_W-FLD_W){1'b0}}, {FLD_W{1'b1}}};
    return base << (CR_W - FLD_W - FLD_W * int'(k));
  endfunction

  function automatic logic [FLD_W-1:0] fld_get(input logic [CR_W-1:0] v,
                                               input logic [FI_W-1:0] k);
    logic [CR_W-1:0] sh;
    sh = v >> (CR_W - FLD_W - FLD_W * int'(k));
    return sh[FLD_W-1:0];
  endfunction
endpackage

// File: rtl/crlu_rst_sync.sv
module crlu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/crlu_cmp.sv
module crlu_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_mode,
  input  logic         so,
  output logic [3:0]   flags
);
  logic lt, gt, eq;

  always_comb begin
    eq = (a == b);
    if (signed_mode) lt = ($signed(a) < $signed(b));
    else             lt = (a < b);
    gt = !lt && !eq;
    flags = {lt, gt, eq, so};
  end
endmodule

// File: rtl/crlu_bitop.sv
module crlu_bitop
  import crlu_pkg::*;
#(
  parameter int W = CR_W
) (
  input  logic [W-1:0]    cr,
  input  logic [BI_W-1:0] ba,
  input  logic [BI_W-1:0] bb,
  input  logic [XO_W-1:0] xo,
  output logic            res,
  output logic            known
);
  localparam logic [BI_W-1:0] TOP = BI_W'(W - 1);
  logic [BI_W-1:0] ia, ib;
  logic x, y;

  always_comb begin
    ia = TOP - ba;
    ib = TOP - bb;
    x  = cr[ia];
    y  = cr[ib];
    known = 1'b1;
    case (xo)
      XO_AND:  res = x & y;
      XO_OR:   res = x | y;
      XO_NAND: res = ~(x & y);
      XO_XOR:  res = x ^ y;
      XO_NOR:  res = ~(x | y);
      XO_EQV:  res = ~(x ^ y);
      XO_ANDC: res = x & ~y;
      XO_ORC:  res = x | ~y;
      default: begin
        res   = 1'b0;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/crlu_fxm.sv
module crlu_fxm
  import crlu_pkg::*;
(
  input  logic [N_FLD-1:0] fxm,
  output logic [CR_W-1:0]  mask
);
  for (genvar i = 0; i < N_FLD; i++) begin : g_nib
    assign mask[FLD_W*i +: FLD_W] = {FLD_W{fxm[i]}};
  end
endmodule

// File: rtl/crlu_top.sv
module crlu_top
  import crlu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [CR_W-1:0]   opnd_a,
  input  logic [CR_W-1:0]   opnd_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic              use_imm,
  input  logic [FI_W-1:0]   fld_dst,
  input  logic [FI_W-1:0]   fld_src,
  input  logic [BI_W-1:0]   bit_a,
  input  logic [BI_W-1:0]   bit_b,
  input  logic [BI_W-1:0]   bit_t,
  input  logic [XO_W-1:0]   xo,
  input  logic [N_FLD-1:0]  fxm,
  input  logic              so_in,
  output logic [CR_W-1:0]   cr_next,
  output logic [CR_W-1:0]   cr_rd
);
  logic              rst_sync_n;
  logic [CR_W-1:0]   cr_q;
  logic [CR_W-1:0]   cr_d;
  logic              cr_en;
  logic [CR_W-1:0]   wr_mask;
  logic [CR_W-1:0]   wr_data;
  logic [CR_W-1:0]   b_eff;
  logic [CR_W-1:0]   nib_mask;
  logic [3:0]        cmp_flags;
  logic              bit_res;
  logic              bit_known;
  logic [FLD_W-1:0]  src_fld;
  logic              is_signed;

  crlu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // Second compare operand: immediate extended per compare kind
  always_comb begin
    is_signed = (op_code == OP_CMPS);
    if (use_imm) begin
      if (is_signed) b_eff = {{(CR_W-IMM_W){imm16[IMM_W-1]}}, imm16};
      else           b_eff = {{(CR_W-IMM_W){1'b0}}, imm16};
    end else begin
      b_eff = opnd_b;
    end
  end

  crlu_cmp #(.W(CR_W)) u_cmp (
    .a(opnd_a), .b(b_eff), .signed_mode(is_signed), .so(so_in), .flags(cmp_flags)
  );

  crlu_bitop #(.W(CR_W)) u_bit (
    .cr(cr_q), .ba(bit_a), .bb(bit_b), .xo(xo), .res(bit_res), .known(bit_known)
  );

  crlu_fxm u_fxm (
    .fxm(fxm), .mask(nib_mask)
  );

  // Next-state: build write mask and data, then merge
  always_comb begin
    wr_mask = '0;
    wr_data = '0;
    src_fld = fld_get(cr_q, fld_src);
    case (op_code)
      OP_CMPS, OP_CMPU: begin
        wr_mask = fld_mask(fld_dst);
        wr_data = {N_FLD{cmp_flags}};
      end
      OP_FMOVE: begin
        wr_mask = fld_mask(fld_dst);
        wr_data = {N_FLD{src_fld}};
      end
      OP_MASK: begin
        wr_mask = nib_mask;
        wr_data = opnd_a;
      end
      OP_BIT: begin
        if (bit_known) wr_mask = CR_W'(1) << (CR_W - 1 - int'(bit_t));
        wr_data = {CR_W{bit_res}};
      end
      default: begin
        wr_mask = '0;
        wr_data = '0;
      end
    endcase
    if (!op_valid) wr_mask = '0;
    cr_en = |wr_mask;
    cr_d  = (cr_q & ~wr_mask) | (wr_data & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cr_q <= '0;
    else if (cr_en)   cr_q <= cr_d;
  end

  assign cr_next = cr_d;
  assign cr_rd   = cr_q;
endmodule

// File: rtl/crlu_chk.sv
module crlu_chk
  import crlu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [CR_W-1:0]   opnd_a,
  input  logic [FI_W-1:0]   fld_dst,
  input  logic [BI_W-1:0]   bit_t,
  input  logic [XO_W-1:0]   xo,
  input  logic [N_FLD-1:0]  fxm,
  input  logic              so_in,
  input  logic [CR_W-1:0]   cr_next,
  input  logic [CR_W-1:0]   cr_rd
);
  logic [FLD_W-1:0] nf;
  logic             is_cmp;
  logic [CR_W-1:0]  keep;

  always_comb begin
    nf     = fld_get(cr_next, fld_dst);
    is_cmp = (op_code == OP_CMPS) || (op_code == OP_CMPU);
    keep   = ~(CR_W'(1) << (CR_W - 1 - int'(bit_t)));
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> cr_rd == $past(cr_rd));

  p_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> cr_rd == $past(cr_next));

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |-> $countones(nf[3:1]) == 1);

  p_so_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |-> nf[0] == so_in);

  p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MASK && fxm == '1) |-> cr_next == opnd_a);

  p_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_BIT) |-> ((cr_next ^ cr_rd) & keep) == '0);

  p_unknown_xo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_BIT && !xo_known(xo)) |-> cr_next == cr_rd);
endmodule

bind crlu_top crlu_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_code(op_code),
  .opnd_a(opnd_a), .fld_dst(fld_dst), .bit_t(bit_t), .xo(xo), .fxm(fxm),
  .so_in(so_in), .cr_next(cr_next), .cr_rd(cr_rd)
);

// File: tb/sim_crlu_top.sv
module sim_crlu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm16;
  logic        use_imm;
  logic [2:0]  fld_dst, fld_src;
  logic [4:0]  bit_a, bit_b, bit_t;
  logic [9:0]  xo;
  logic [7:0]  fxm;
  logic        so_in;
  logic [31:0] cr_next, cr_rd;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_cr;

  always #4 clk = ~clk;

  crlu_top u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .use_imm(use_imm),
    .fld_dst(fld_dst), .fld_src(fld_src), .bit_a(bit_a), .bit_b(bit_b),
    .bit_t(bit_t), .xo(xo), .fxm(fxm), .so_in(so_in),
    .cr_next(cr_next), .cr_rd(cr_rd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Compare by subtraction; signed handled by flipping sign bits
  function automatic logic [3:0] m_cmp(input logic [31:0] a, input logic [31:0] b,
                                       input logic sgn, input logic so);
    logic [31:0] aa, bb;
    logic [32:0] d;
    aa = sgn ? (a ^ 32'h8000_0000) : a;
    bb = sgn ? (b ^ 32'h8000_0000) : b;
    d  = {1'b0, aa} - {1'b0, bb};
    if (aa == bb)  return {3'b001, so};
    else if (d[32]) return {3'b100, so};
    else           return {3'b010, so};
  endfunction

  function automatic logic [31:0] m_next(
      input logic [31:0] cr, input logic v, input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] im, input logic ui,
      input logic [2:0] fd, input logic [2:0] fs, input logic [4:0] ba, input logic [4:0] bb,
      input logic [4:0] bt, input logic [9:0] x, input logic [7:0] m, input logic so);
    logic [31:0] r, bv;
    logic [3:0] f;
    logic p, q, o, ok;
    r = cr;
    if (!v) return r;
    case (op)
      3'd1, 3'd2: begin
        bv = b;
        if (ui) bv = (op == 3'd1) ? {{16{im[15]}}, im} : {16'h0, im};
        f = m_cmp(a, bv, op == 3'd1, so);
        for (int j = 0; j < 4; j++) r[31 - (4*fd + j)] = f[3 - j];
      end
      3'd3: for (int j = 0; j < 4; j++) r[31 - (4*fd + j)] = cr[31 - (4*fs + j)];
      3'd4: for (int i = 0; i < 8; i++)
              if (m[i]) for (int j = 0; j < 4; j++) r[4*i + j] = a[4*i + j];
      3'd5: begin
        p = cr[31 - ba]; q = cr[31 - bb]; ok = 1'b1; o = 1'b0;
        case (x)
          10'd257: o = p & q;
          10'd449: o = p | q;
          10'd255: o = !(p && q);
          10'd193: o = p ^ q;
          10'd33:  o = !(p || q);
          10'd289: o = (p == q);
          10'd129: o = p & !q;
          10'd417: o = p | !q;
          default: ok = 1'b0;
        endcase
        if (ok) r[31 - bt] = o;
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic v, input logic [2:0] op, input logic ui,
                                   input logic [9:0] x);
    if (!v) return "R9";
    case (op)
      3'd1: return ui ? "R4" : "R2";
      3'd2: return ui ? "R4" : "R3";
      3'd3: return "R8";
      3'd4: return "R5";
      3'd5: return (x == 10'd257 || x == 10'd449 || x == 10'd255 || x == 10'd193 ||
                    x == 10'd33 || x == 10'd289 || x == 10'd129 || x == 10'd417) ? "R6" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im, input logic ui,
                        input logic [2:0] fd, input logic [2:0] fs, input logic [4:0] ba,
                        input logic [4:0] bb, input logic [4:0] bt, input logic [9:0] x,
                        input logic [7:0] m, input logic so);
    logic [31:0] e;
    string t;
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; imm16 = im; use_imm = ui;
    fld_dst = fd; fld_src = fs; bit_a = ba; bit_b = bb; bit_t = bt; xo = x; fxm = m; so_in = so;
    e = m_next(exp_cr, v, op, a, b, im, ui, fd, fs, ba, bb, bt, x, m, so);
    t = tag_of(v, op, ui, x);
    #1;
    check("R10 pre-update read", cr_rd, exp_cr);
    check({t, " next value"}, cr_next, e);
    @(posedge clk); #1;
    check({t, " committed"}, cr_rd, e);
    exp_cr = e;
  endtask

  task automatic bit_case(input logic [4:0] ba, input logic [4:0] bb, input logic [4:0] bt,
                          input logic [9:0] x);
    run_op(1, 3'd5, 0, 0, 0, 0, 0, 0, ba, bb, bt, x, 0, 0);
  endtask

  initial begin : wd
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [2:0] rop;
    logic [9:0] rx;
    logic [9:0] xos [8];
    void'($urandom(32'h5eed_1234));
    xos = '{10'd257, 10'd449, 10'd255, 10'd193, 10'd33, 10'd289, 10'd129, 10'd417};
    rst_n = 1'b0; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0; imm16 = 0; use_imm = 0;
    fld_dst = 0; fld_src = 0; bit_a = 0; bit_b = 0; bit_t = 0; xo = 0; fxm = 0; so_in = 0;
    exp_cr = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset value", cr_rd, 32'h0);

    // R5 masked load: all nibbles, none, alternating
    run_op(1, 3'd4, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
    run_op(1, 3'd4, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    run_op(1, 3'd4, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hA5, 0);
    // R2/R3: signed vs unsigned with most negative value
    run_op(1, 3'd1, 32'h8000_0000, 32'h1, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, 1);
    run_op(1, 3'd2, 32'h8000_0000, 32'h1, 0, 0, 3'd7, 0, 0, 0, 0, 0, 0, 0);
    run_op(1, 3'd1, 32'h55, 32'h55, 0, 0, 3'd3, 0, 0, 0, 0, 0, 0, 0);
    // R4: immediate 0xFFFF is -1 signed, 65535 unsigned
    run_op(1, 3'd1, 32'h0, 0, 16'hFFFF, 1, 3'd2, 0, 0, 0, 0, 0, 0, 0);
    run_op(1, 3'd2, 32'h0, 0, 16'hFFFF, 1, 3'd5, 0, 0, 0, 0, 0, 0, 1);
    run_op(1, 3'd2, 32'h0000_FFFF, 32'h0, 16'hFFFF, 1, 3'd6, 0, 0, 0, 0, 0, 0, 0);
    // R8 field copy across ends
    run_op(1, 3'd3, 0, 0, 0, 0, 3'd7, 3'd0, 0, 0, 0, 0, 0, 0);
    run_op(1, 3'd3, 0, 0, 0, 0, 3'd1, 3'd1, 0, 0, 0, 0, 0, 0);
    // R6 each function, R7 unknown codes
    for (int k = 0; k < 8; k++) bit_case(5'd0, 5'd31, 5'(k + 8), xos[k]);
    for (int k = 0; k < 8; k++) bit_case(5'd4, 5'd4, 5'(k + 16), xos[k]);
    bit_case(5'd0, 5'd1, 5'd2, 10'd0);
    bit_case(5'd0, 5'd1, 5'd2, 10'd1023);
    // R9: invalid, and undefined op codes
    run_op(0, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
    run_op(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
    run_op(1, 3'd6, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
    run_op(1, 3'd7, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0);

    // Random mix (R2-R9, R11 through compare results)
    for (int n = 0; n < 600; n++) begin
      rop = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) rx = 10'($urandom);
      else rx = xos[$urandom_range(0, 7)];
      run_op(($urandom_range(0, 9) != 0), rop, $urandom,
             ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom, 16'($urandom),
             1'($urandom), 3'($urandom), 3'($urandom), 5'($urandom), 5'($urandom),
             5'($urandom), rx, 8'($urandom), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule